// File: doc/BRIEF.md
# Non-posted request tag tracker

This block sits beside the request path of a transaction-layer requester. It keeps
track of every outstanding request that expects a completion and matches each
returning completion to its request by tag. Each request is classified by type:
posted types (memory write, message, message with data) pass without holding
anything. Every other type takes the lowest free tag from a 32-entry table, and the
tracker drives that tag number to the requester. A read entry records the number of
doublewords it still owes and stays open across several data completions. A write
entry closes on its single completion without data. A locked read accepts only the
locked completion types.

Completions come in as header descriptors. These carry a type, a tag, a 3-bit status
and a data length in doublewords. The tracker checks each one against the entry it
names. An entry retires when it is finished. A partial read only lowers the count
still owed. Anything that does not fit is reported as unexpected, and the table is
left untouched. Results appear one cycle after the completion as single-cycle event
pulses.

Both descriptor inputs use valid/ready. A request transfers on a cycle where
`req_valid` and `req_ready` are both high. `req_ready` depends on `req_type` in the
same cycle: it is always high for a posted type, and for a non-posted type it is high
only while a free tag exists. The requester must hold its descriptor until it is
taken. `cpl_ready` is tied high, so the completion side never applies back-pressure
and a completion is taken on every cycle in which `cpl_valid` is high.

Top module: `np_tag_tracker`

## Requirements
- R1: Request types 8 (memory write), 9 (message) and 10 (message with data), and the unused codes 11 to 15, are posted. They are accepted with `req_ready` high whatever the table holds, they allocate no entry, and `req_tag` does not change.
- R2: Request types 0 (memory read), 1 (locked memory read), 2 (IO read), 3 (IO write), 4 and 5 (configuration read, type 0 and 1) and 6 and 7 (configuration write, type 0 and 1) are non-posted. Each one takes the tag shown on `req_tag`, which is the lowest-numbered free entry. That tag stays occupied until the request retires.
- R3: When all 32 entries are occupied, `req_ready` is low for any non-posted type and high for any posted type. A non-posted request offered while `req_ready` is low changes nothing.
- R4: Completion type 1 (data, unlocked) with status 0 and a length from 1 up to the doublewords still owed lowers what a read (types 0, 2, 4, 5) still owes. When the total requested length has arrived, the entry retires with `evt_done`=1, `evt_fail`=0, and its tag becomes free.
- R5: Completion type 0 (no data, unlocked) with a status other than 0 ends an unlocked read entry, with `evt_done`=1 and `evt_fail`=1.
- R6: A write entry (types 3, 6, 7) retires on one completion of type 0. `evt_fail` is 1 exactly when the status is not 0.
- R7: A locked read accepts only type 3 (data, locked) and type 2 (no data, locked). Type 3 with status 0 follows the R4 counting rules. Type 2 with a nonzero status retires the entry with `evt_fail`=1 and `evt_lock_lost`=1.
- R8: The tracker raises `evt_unexpected` and changes no entry for any completion that does not fit its tag. This covers a tag with no open entry, a type or status not allowed for the entry kind, a data length of 0, a length above the doublewords still owed, and a length above 1024 doublewords (4 KB).
- R9: A completion and a new request in the same cycle are both applied. The retired tag is free from the next cycle, so `req_tag` then shows it if it is the lowest free tag.
- R10: After reset the table is empty, `req_tag` is 0, and all event outputs are low. Each accepted completion yields exactly one pulse one cycle later: either `evt_done`, with `evt_tag` carrying the completion's tag, or `evt_unexpected`, or no pulse at all for a partial read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request descriptor valid |
| req_ready | output | 1 | Request accepted this cycle when high together with valid |
| req_type | input | 4 | Request type code (see R1, R2) |
| req_len | input | 11 | Requested length in doublewords (used for reads) |
| req_tag | output | 5 | Tag granted to a non-posted request this cycle (lowest free) |
| cpl_valid | input | 1 | Completion descriptor valid |
| cpl_ready | output | 1 | Always high; completions are never stalled |
| cpl_type | input | 2 | 0 no data, 1 data, 2 locked no data, 3 locked data |
| cpl_tag | input | 5 | Tag carried by the completion |
| cpl_status | input | 3 | Completion status, 0 means success |
| cpl_len | input | 11 | Data length of the completion in doublewords |
| evt_done | output | 1 | Pulse: an entry retired |
| evt_tag | output | 5 | Tag of the retired entry |
| evt_fail | output | 1 | With evt_done: the request ended in error |
| evt_lock_lost | output | 1 | With evt_done: a locked read failed, lock atomicity lost |
| evt_unexpected | output | 1 | Pulse: completion did not fit and was dropped |

## Verification
The assertions assume that the requester holds `req_type` and `req_len` stable while
`req_valid` waits for `req_ready`. They also assume that no read is ever issued with a
length of zero, since such an entry could never retire. The stimulus offers only
non-zero read lengths and changes request fields only between cycles. It deliberately
sends completions that are malformed, that name an unknown tag, or that are too long.
This exercises the drop path and then shows, through later legal completions and
`req_tag`, that the table kept its contents.

// File: rtl/np_trk_pkg.sv
package np_trk_pkg;

  localparam int unsigned NUM_TAGS   = 32;
  localparam int unsigned TAG_W      = $clog2(NUM_TAGS);
  localparam int unsigned DW_W       = 11;
  localparam int unsigned MAX_CPL_DW = 1024;

  localparam logic [3:0] RQ_MEM_RD    = 4'd0;
  localparam logic [3:0] RQ_MEM_RD_LK = 4'd1;
  localparam logic [3:0] RQ_IO_RD     = 4'd2;
  localparam logic [3:0] RQ_IO_WR     = 4'd3;
  localparam logic [3:0] RQ_CFG_RD0   = 4'd4;
  localparam logic [3:0] RQ_CFG_RD1   = 4'd5;
  localparam logic [3:0] RQ_CFG_WR0   = 4'd6;
  localparam logic [3:0] RQ_CFG_WR1   = 4'd7;

  localparam logic [1:0] CP_NODATA    = 2'd0;
  localparam logic [1:0] CP_DATA      = 2'd1;
  localparam logic [1:0] CP_NODATA_LK = 2'd2;
  localparam logic [1:0] CP_DATA_LK   = 2'd3;

  typedef enum logic [1:0] {
    EK_READ  = 2'd0,
    EK_LOCK  = 2'd1,
    EK_WRITE = 2'd2
  } ent_kind_e;

endpackage

// File: rtl/np_trk_classify.sv
module np_trk_classify
  import np_trk_pkg::*;
(
  input  logic [3:0] rtype,
  output logic       needs_entry,
  output ent_kind_e  kind
);
  always_comb begin
    needs_entry = 1'b1;
    kind        = EK_READ;
    case (rtype)
      RQ_MEM_RD, RQ_IO_RD, RQ_CFG_RD0, RQ_CFG_RD1: kind = EK_READ;
      RQ_MEM_RD_LK:                                kind = EK_LOCK;
      RQ_IO_WR, RQ_CFG_WR0, RQ_CFG_WR1:            kind = EK_WRITE;
      default:                                     needs_entry = 1'b0;
    endcase
  end
endmodule

// File: rtl/np_trk_alloc.sv
module np_trk_alloc #(
  parameter int unsigned N = 32,
  localparam int unsigned TW = $clog2(N)
) (
  input  logic [N-1:0]  busy,
  output logic          any_free,
  output logic [TW-1:0] tag
);
  always_comb begin
    any_free = ~&busy;
    tag      = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) tag = TW'(i);
    end
  end
endmodule

// File: rtl/np_trk_entry.sv
module np_trk_entry
  import np_trk_pkg::*;
#(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         alloc,
  input  ent_kind_e    alloc_kind,
  input  logic [W-1:0] alloc_len,
  input  logic         upd,
  input  logic         retire,
  input  logic [W-1:0] new_rem,
  output logic         valid,
  output ent_kind_e    kind,
  output logic [W-1:0] rem
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      kind  <= EK_READ;
      rem   <= '0;
    end else if (alloc) begin
      valid <= 1'b1;
      kind  <= alloc_kind;
      rem   <= alloc_len;
    end else if (retire) begin
      valid <= 1'b0;
      rem   <= '0;
    end else if (upd) begin
      rem   <= new_rem;
    end
  end
endmodule

// File: rtl/np_trk_cpl_check.sv
module np_trk_cpl_check
  import np_trk_pkg::*;
#(
  parameter int unsigned W      = 11,
  parameter int unsigned MAX_DW = 1024
) (
  input  logic         ent_valid,
  input  ent_kind_e    ent_kind,
  input  logic [W-1:0] ent_rem,
  input  logic [1:0]   ctype,
  input  logic [2:0]   cstatus,
  input  logic [W-1:0] clen,
  output logic         upd,
  output logic         retire,
  output logic         fail,
  output logic         lock_lost,
  output logic         unexp,
  output logic [W-1:0] new_rem
);
  logic       st_ok;
  logic       len_ok;
  logic [1:0] want_data;
  logic [1:0] want_nodata;

  assign st_ok   = (cstatus == 3'd0);
  assign len_ok  = (clen != '0) && (clen <= ent_rem) && (clen <= W'(MAX_DW));
  assign new_rem = ent_rem - clen;

  always_comb begin
    want_data   = (ent_kind == EK_LOCK) ? CP_DATA_LK : CP_DATA;
    want_nodata = (ent_kind == EK_LOCK) ? CP_NODATA_LK : CP_NODATA;
    upd       = 1'b0;
    retire    = 1'b0;
    fail      = 1'b0;
    lock_lost = 1'b0;
    unexp     = 1'b0;
    if (!ent_valid) begin
      unexp = 1'b1;
    end else if (ent_kind == EK_WRITE) begin
      if (ctype == CP_NODATA) begin
        retire = 1'b1;
        fail   = !st_ok;
      end else begin
        unexp = 1'b1;
      end
    end else if (ctype == want_data && st_ok && len_ok) begin
      upd    = 1'b1;
      retire = (clen == ent_rem);
    end else if (ctype == want_nodata && !st_ok) begin
      retire    = 1'b1;
      fail      = 1'b1;
      lock_lost = (ent_kind == EK_LOCK);
    end else begin
      unexp = 1'b1;
    end
  end
endmodule

// File: rtl/np_tag_tracker.sv
module np_tag_tracker
  import np_trk_pkg::*;
#(
  parameter int unsigned N_TAGS = NUM_TAGS,
  parameter int unsigned LEN_W  = DW_W,
  parameter int unsigned MAX_DW = MAX_CPL_DW,
  localparam int unsigned TW    = $clog2(N_TAGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [3:0]       req_type,
  input  logic [LEN_W-1:0] req_len,
  output logic [TW-1:0]    req_tag,
  input  logic             cpl_valid,
  output logic             cpl_ready,
  input  logic [1:0]       cpl_type,
  input  logic [TW-1:0]    cpl_tag,
  input  logic [2:0]       cpl_status,
  input  logic [LEN_W-1:0] cpl_len,
  output logic             evt_done,
  output logic [TW-1:0]    evt_tag,
  output logic             evt_fail,
  output logic             evt_lock_lost,
  output logic             evt_unexpected
);
  logic [N_TAGS-1:0] ent_valid;
  ent_kind_e         ent_kind [N_TAGS];
  logic [LEN_W-1:0]  ent_rem  [N_TAGS];

  logic      needs;
  ent_kind_e rq_kind;
  logic      any_free;
  logic      alloc_fire;

  np_trk_classify u_cls (
    .rtype       (req_type),
    .needs_entry (needs),
    .kind        (rq_kind)
  );

  np_trk_alloc #(.N(N_TAGS)) u_alloc (
    .busy     (ent_valid),
    .any_free (any_free),
    .tag      (req_tag)
  );

  assign req_ready  = needs ? any_free : 1'b1;
  assign alloc_fire = req_valid && req_ready && needs;
  assign cpl_ready  = 1'b1;

  logic             c_upd, c_retire, c_fail, c_lock, c_unexp;
  logic [LEN_W-1:0] c_new_rem;

  np_trk_cpl_check #(.W(LEN_W), .MAX_DW(MAX_DW)) u_chk (
    .ent_valid (ent_valid[cpl_tag]),
    .ent_kind  (ent_kind[cpl_tag]),
    .ent_rem   (ent_rem[cpl_tag]),
    .ctype     (cpl_type),
    .cstatus   (cpl_status),
    .clen      (cpl_len),
    .upd       (c_upd),
    .retire    (c_retire),
    .fail      (c_fail),
    .lock_lost (c_lock),
    .unexp     (c_unexp),
    .new_rem   (c_new_rem)
  );

  for (genvar g = 0; g < N_TAGS; g++) begin : g_ent
    logic hit_c;
    assign hit_c = cpl_valid && (cpl_tag == TW'(g));
    np_trk_entry #(.W(LEN_W)) u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc      (alloc_fire && (req_tag == TW'(g))),
      .alloc_kind (rq_kind),
      .alloc_len  (req_len),
      .upd        (hit_c && c_upd),
      .retire     (hit_c && c_retire),
      .new_rem    (c_new_rem),
      .valid      (ent_valid[g]),
      .kind       (ent_kind[g]),
      .rem        (ent_rem[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_done       <= 1'b0;
      evt_tag        <= '0;
      evt_fail       <= 1'b0;
      evt_lock_lost  <= 1'b0;
      evt_unexpected <= 1'b0;
    end else begin
      evt_done       <= cpl_valid && c_retire;
      evt_tag        <= cpl_tag;
      evt_fail       <= cpl_valid && c_retire && c_fail;
      evt_lock_lost  <= cpl_valid && c_retire && c_lock;
      evt_unexpected <= cpl_valid && c_unexp;
    end
  end

  assert_posted_no_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !needs && !cpl_valid) |=> $stable(ent_valid));

  assert_alloc_free_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> !ent_valid[req_tag]);

  assert_alloc_sets_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> ent_valid[$past(req_tag)]);

  assert_full_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (needs && (&ent_valid)) |-> !req_ready);

  assert_retire_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && c_retire) |=> !ent_valid[$past(cpl_tag)]);

  assert_lock_lost_is_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_lock_lost |-> (evt_done && evt_fail));

  assert_unexp_keeps_table_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && c_unexp && !alloc_fire) |=> $stable(ent_valid));

  assert_one_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_done && evt_unexpected));

endmodule

// File: tb/np_tag_tracker_bench.sv
`timescale 1ns/1ps
module np_tag_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_type = 4'd0;
  logic [10:0] req_len = 11'd0;
  logic [4:0]  req_tag;
  logic        cpl_valid = 1'b0;
  logic        cpl_ready;
  logic [1:0]  cpl_type = 2'd0;
  logic [4:0]  cpl_tag = 5'd0;
  logic [2:0]  cpl_status = 3'd0;
  logic [10:0] cpl_len = 11'd0;
  logic        evt_done, evt_fail, evt_lock_lost, evt_unexpected;
  logic [4:0]  evt_tag;

  always #4 clk = ~clk;

  np_tag_tracker u_np_tag_tracker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_len(req_len), .req_tag(req_tag),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_type(cpl_type),
    .cpl_tag(cpl_tag), .cpl_status(cpl_status), .cpl_len(cpl_len),
    .evt_done(evt_done), .evt_tag(evt_tag), .evt_fail(evt_fail),
    .evt_lock_lost(evt_lock_lost), .evt_unexpected(evt_unexpected)
  );

  typedef struct packed {
    logic       unexp;
    logic [4:0] tag;
    logic       fail;
    logic       lock;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;

  task automatic chk(input string rq, input int got, input int want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", rq, got, want);
    end
  endtask

  // monitor: pop one expectation per event pulse
  always @(negedge clk) begin
    if (rst_n && (evt_done || evt_unexpected)) begin
      exp_t got;
      got.unexp = evt_unexpected;
      got.tag   = evt_unexpected ? 5'd0 : evt_tag;
      got.fail  = evt_unexpected ? 1'b0 : evt_fail;
      got.lock  = evt_unexpected ? 1'b0 : evt_lock_lost;
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R10: event %0h with nothing expected", got);
      end else begin
        exp_t  e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk({r, " event"}, int'(got), int'(e));
        chk({r, " single pulse"}, int'(evt_done && evt_unexpected), 0);
      end
    end
  end

  // one cycle: drive at negedge, accepted at posedge
  task automatic step(input bit rv, input logic [3:0] rt, input logic [10:0] rl,
                      input bit cv, input logic [1:0] ct, input logic [4:0] ctg,
                      input logic [2:0] cs, input logic [10:0] cl,
                      input bit has_ev, input exp_t e, input string rq);
    @(negedge clk);
    req_valid = rv; req_type = rt; req_len = rl;
    cpl_valid = cv; cpl_type = ct; cpl_tag = ctg; cpl_status = cs; cpl_len = cl;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    cpl_valid = 1'b0;
    if (has_ev) begin
      exp_q.push_back(e);
      req_q.push_back(rq);
    end
  endtask

  function automatic exp_t ev_done(input logic [4:0] t, input bit f, input bit l);
    exp_t e;
    e.unexp = 1'b0; e.tag = t; e.fail = f; e.lock = l;
    return e;
  endfunction

  function automatic exp_t ev_unexp();
    exp_t e;
    e = '0;
    e.unexp = 1'b1;
    return e;
  endfunction

  task automatic rq(input logic [3:0] t, input logic [10:0] l);
    step(1, t, l, 0, 0, 0, 0, 0, 0, '0, "");
  endtask

  task automatic cp(input logic [1:0] t, input logic [4:0] tg, input logic [2:0] s,
                    input logic [10:0] l, input bit has_ev, input exp_t e,
                    input string r);
    step(0, 4'd0, 0, 1, t, tg, s, l, has_ev, e, r);
  endtask

  task automatic look(input string r, input logic [3:0] t, input int want_tag,
                      input int want_ready);
    @(negedge clk);
    req_type = t;
    #1;
    chk({r, " req_tag"}, int'(req_tag), want_tag);
    chk({r, " req_ready"}, int'(req_ready), want_ready);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset req_tag", int'(req_tag), 0);
    chk("R10 reset events", int'({evt_done, evt_fail, evt_lock_lost, evt_unexpected}), 0);
    chk("R10 cpl_ready", int'(cpl_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 posted types hold no tag
    rq(4'd8, 11'd16);
    rq(4'd9, 11'd0);
    rq(4'd10, 11'd4);
    look("R1 after posted", 4'd8, 0, 1);
    look("R1 unused code", 4'd13, 0, 1);

    // R2 non-posted allocation, lowest free
    rq(4'd0, 11'd8);    // tag 0 read of 8 dw
    look("R2 after MRd", 4'd0, 1, 1);
    rq(4'd3, 11'd1);    // tag 1 IO write
    rq(4'd4, 11'd1);    // tag 2 config read
    rq(4'd1, 11'd4);    // tag 3 locked read
    look("R2 after four", 4'd0, 4, 1);

    // R4 / R8 split read on tag 0
    cp(2'd1, 5'd0, 3'd0, 11'd3, 0, '0, "");
    cp(2'd1, 5'd0, 3'd0, 11'd6, 1, ev_unexp(), "R8 length above remaining");
    cp(2'd1, 5'd0, 3'd0, 11'd0, 1, ev_unexp(), "R8 zero length");
    cp(2'd1, 5'd0, 3'd0, 11'd5, 1, ev_done(5'd0, 0, 0), "R4 read complete");
    look("R4 tag freed", 4'd0, 0, 1);

    // R6 write with success
    cp(2'd0, 5'd1, 3'd0, 11'd0, 1, ev_done(5'd1, 0, 0), "R6 write ok");
    // R5 read failed
    cp(2'd1, 5'd2, 3'd1, 11'd1, 1, ev_unexp(), "R8 data with bad status");
    cp(2'd0, 5'd2, 3'd1, 11'd0, 1, ev_done(5'd2, 1, 0), "R5 read failed");
    // R7 locked read
    cp(2'd1, 5'd3, 3'd0, 11'd2, 1, ev_unexp(), "R8 unlocked data on locked read");
    cp(2'd3, 5'd3, 3'd0, 11'd2, 0, '0, "");
    cp(2'd2, 5'd3, 3'd4, 11'd0, 1, ev_done(5'd3, 1, 1), "R7 lock lost");
    // R8 unknown tag
    cp(2'd0, 5'd7, 3'd0, 11'd0, 1, ev_unexp(), "R8 unknown tag");
    look("R8 table empty", 4'd0, 0, 1);

    // R3 fill the table
    for (int i = 0; i < 32; i++) begin
      look("R2 fill", 4'd6, i, 1);
      rq(4'd6, 11'd1);
    end
    look("R3 full non-posted", 4'd0, 0, 0);
    step(1, 4'd0, 11'd2, 0, 0, 0, 0, 0, 0, '0, "");   // refused
    look("R3 full posted", 4'd8, 0, 1);

    cp(2'd0, 5'd10, 3'd0, 11'd0, 1, ev_done(5'd10, 0, 0), "R6 write retire");
    look("R3 refused request took nothing", 4'd0, 10, 1);

    // R9 completion and request together
    step(1, 4'd3, 11'd1, 1, 2'd0, 5'd3, 3'd0, 11'd0, 1, ev_done(5'd3, 0, 0), "R9 retire with alloc");
    look("R9 retired tag reusable", 4'd3, 3, 1);

    // R8 wrong type on write, then legal completion shows entry kept
    cp(2'd1, 5'd4, 3'd0, 11'd1, 1, ev_unexp(), "R8 data on write");
    cp(2'd0, 5'd4, 3'd2, 11'd0, 1, ev_done(5'd4, 1, 0), "R6 write error status");
    look("R6 lowest free", 4'd0, 3, 1);

    // R4 / R8 large read with 4 KB cap
    rq(4'd0, 11'd1500);  // tag 3
    cp(2'd1, 5'd3, 3'd0, 11'd1100, 1, ev_unexp(), "R8 above 4 KB");
    cp(2'd1, 5'd3, 3'd0, 11'd1024, 0, '0, "");
    look("R4 still open", 4'd0, 4, 1);
    cp(2'd1, 5'd3, 3'd0, 11'd476, 1, ev_done(5'd3, 0, 0), "R4 multi completion");
    look("R4 tag freed again", 4'd0, 3, 1);

    repeat (3) @(negedge clk);
    chk("R10 all events seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule